// File: doc/BRIEF.md
# Dual-Port Address Collision Arbiter

This block sits beside a shared two-port memory array and watches both ports every clock. When both ports are enabled on the same full address, it decides which port keeps the location. The port that was already parked on that address wins. If both land in the same cycle, the left port wins. The other port is the loser: in master mode it gets a registered busy flag, and its array write strobes are suppressed.

The block has two modes, set by a mode pin. In master mode it drives the busy flags itself. In slave mode the busy flags come in from outside, typically from a master arbiter placed next to a wider array. The block's own busy outputs then stay low, and each incoming flag only holds off writes from its port. In both modes the block also produces per-byte-lane write qualifiers for the array. A lane is written only when its port is enabled, in write mode, the lane's enable is set, and the port is not held off.

Top module: `dpc_collide`

## Requirements
- R1: In master mode, when both ports are enabled and their full addresses are equal in a cycle, the losing port's busy output is high in the following cycle.
- R2: A busy output is low in the cycle after a cycle in which the addresses differ or either port is disabled.
- R3: A port counts as already present when it was enabled on the same address in the previous cycle. When a match begins and exactly one port was already present, that port wins and the other one is the loser.
- R4: When a match begins and neither or both ports were already present, the left port wins. The two busy outputs are never high together.
- R5: While the match continues without a break, the winner does not change, even if both ports move together to a new common address.
- R6: In master mode, a port's write qualifiers are all zero in every cycle in which it is the current loser or its busy output is high.
- R7: In slave mode both busy outputs are low, and a high busy input forces its port's write qualifiers to zero. In master mode the busy inputs have no effect.
- R8: Write qualifier bit i (bit 1 = upper lane, bit 0 = lower lane) is high only when its port is enabled, its write signal is high, lane enable i is high, and the port is not held off. A read (write signal low) produces no qualifier.
- R9: A port reading a location that the other port already holds for writing is the loser and gets busy.
- R10: The comparison uses every address bit, so addresses that differ only in the top bit never collide.
- R11: During reset both busy outputs are low and no winner is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_mode | input | 1 | 1 = drive busy outputs, 0 = take busy inputs |
| l_en | input | 1 | Left port enable |
| l_wr | input | 1 | Left port write (1) or read (0) |
| l_addr | input | AW | Left port address |
| l_lane | input | LANES | Left byte lane enables |
| r_en | input | 1 | Right port enable |
| r_wr | input | 1 | Right port write (1) or read (0) |
| r_addr | input | AW | Right port address |
| r_lane | input | LANES | Right byte lane enables |
| l_busy_in | input | 1 | External hold for left writes (slave mode) |
| r_busy_in | input | 1 | External hold for right writes (slave mode) |
| l_busy_out | output | 1 | Left port busy (master mode) |
| r_busy_out | output | 1 | Right port busy (master mode) |
| l_we | output | LANES | Left per-lane array write qualifiers |
| r_we | output | LANES | Right per-lane array write qualifiers |

## Verification
Two events can land in the same cycle: a match starts, and the loser's write attempt arrives. The write must be suppressed at once, even though the loser's busy flag only rises one cycle later. The bench provokes this by bringing both ports onto a common address in one cycle with both writing. It also has one port join a location the other already holds, and it keeps the loser writing through the cycle in which the match ends. A behavioural model predicts the busy flags and the write qualifiers for every cycle. The bench compares all four outputs on every clock, so a write qualifier that leaks in the first match cycle or in the trailing busy cycle is reported.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int NPORT = 2;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'b00,
    OWN_LEFT  = 2'b01,
    OWN_RIGHT = 2'b10
  } owner_e;
endpackage

// File: rtl/dpc_port_track.sv
// Remembers whether a port was enabled on the same address last cycle.
module dpc_port_track #(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic          stay
);
  logic          en_q, en_d;
  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    en_d   = en;
    addr_d = addr;
    stay   = en && en_q && (addr == addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      addr_q <= '0;
    end else begin
      en_q   <= en_d;
      addr_q <= addr_d;
    end
  end
endmodule

// File: rtl/dpc_arbiter.sv
// Match detection, winner selection and registered busy flags.
module dpc_arbiter
  import dpc_pkg::*;
#(
  parameter int AW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          master,
  input  logic          l_en,
  input  logic          r_en,
  input  logic [AW-1:0] l_addr,
  input  logic [AW-1:0] r_addr,
  input  logic          l_stay,
  input  logic          r_stay,
  output logic          loser_l,
  output logic          loser_r,
  output logic          busy_l_q,
  output logic          busy_r_q
);
  owner_e owner_q, owner_d;
  logic   match;
  logic   busy_l_d, busy_r_d;

  always_comb begin
    match   = l_en && r_en && (l_addr == r_addr);
    owner_d = OWN_NONE;
    if (match) begin
      if (owner_q != OWN_NONE)       owner_d = owner_q;
      else if (r_stay && !l_stay)    owner_d = OWN_RIGHT;
      else                           owner_d = OWN_LEFT;
    end
    loser_l  = match && (owner_d == OWN_RIGHT);
    loser_r  = match && (owner_d == OWN_LEFT);
    busy_l_d = master && loser_l;
    busy_r_d = master && loser_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q  <= OWN_NONE;
      busy_l_q <= 1'b0;
      busy_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      busy_l_q <= busy_l_d;
      busy_r_q <= busy_r_d;
    end
  end

  assert_owner_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (match && $past(match)) |-> (owner_d == $past(owner_d)));

  assert_no_dual_loser_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(loser_l && loser_r));

  assert_owner_cleared_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (owner_q == OWN_NONE));
endmodule

// File: rtl/dpc_wr_gate.sv
// Per-lane write qualifier for one port.
module dpc_wr_gate #(
  parameter int LANES = 2
) (
  input  logic             en,
  input  logic             wr,
  input  logic [LANES-1:0] lane,
  input  logic             block,
  output logic [LANES-1:0] we
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      we[i] = en && wr && lane[i] && !block;
    end
  end
endmodule

// File: rtl/dpc_collide.sv
module dpc_collide
  import dpc_pkg::*;
#(
  parameter int AW    = 13,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             master_mode,
  input  logic             l_en,
  input  logic             l_wr,
  input  logic [AW-1:0]    l_addr,
  input  logic [LANES-1:0] l_lane,
  input  logic             r_en,
  input  logic             r_wr,
  input  logic [AW-1:0]    r_addr,
  input  logic [LANES-1:0] r_lane,
  input  logic             l_busy_in,
  input  logic             r_busy_in,
  output logic             l_busy_out,
  output logic             r_busy_out,
  output logic [LANES-1:0] l_we,
  output logic [LANES-1:0] r_we
);
  logic             en_v    [NPORT];
  logic             wr_v    [NPORT];
  logic [AW-1:0]    addr_v  [NPORT];
  logic [LANES-1:0] lane_v  [NPORT];
  logic             stay_v  [NPORT];
  logic             block_v [NPORT];
  logic [LANES-1:0] we_v    [NPORT];
  logic             loser_l, loser_r, busy_l_q, busy_r_q;

  assign en_v[0]   = l_en;
  assign en_v[1]   = r_en;
  assign wr_v[0]   = l_wr;
  assign wr_v[1]   = r_wr;
  assign addr_v[0] = l_addr;
  assign addr_v[1] = r_addr;
  assign lane_v[0] = l_lane;
  assign lane_v[1] = r_lane;

  always_comb begin
    block_v[0] = master_mode ? (loser_l || busy_l_q) : l_busy_in;
    block_v[1] = master_mode ? (loser_r || busy_r_q) : r_busy_in;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    dpc_port_track #(.AW(AW)) u_trk (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (en_v[p]),
      .addr (addr_v[p]),
      .stay (stay_v[p])
    );
    dpc_wr_gate #(.LANES(LANES)) u_gate (
      .en   (en_v[p]),
      .wr   (wr_v[p]),
      .lane (lane_v[p]),
      .block(block_v[p]),
      .we   (we_v[p])
    );
  end

  dpc_arbiter #(.AW(AW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .master  (master_mode),
    .l_en    (l_en),
    .r_en    (r_en),
    .l_addr  (l_addr),
    .r_addr  (r_addr),
    .l_stay  (stay_v[0]),
    .r_stay  (stay_v[1]),
    .loser_l (loser_l),
    .loser_r (loser_r),
    .busy_l_q(busy_l_q),
    .busy_r_q(busy_r_q)
  );

  assign l_busy_out = busy_l_q;
  assign r_busy_out = busy_r_q;
  assign l_we       = we_v[0];
  assign r_we       = we_v[1];

  assert_busy_needs_match_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy_out || r_busy_out) |-> $past(master_mode && l_en && r_en && (l_addr == r_addr)));

  assert_busy_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(l_en && r_en && (l_addr == r_addr))) |-> (!l_busy_out && !r_busy_out));

  assert_single_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy_out && r_busy_out));

  assert_loser_write_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    master_mode |-> ((!l_busy_out || l_we == '0) && (!r_busy_out || r_we == '0)));

  assert_slave_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> ((!l_busy_in || l_we == '0) && (!r_busy_in || r_we == '0)));

  assert_lane_subset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((l_we & ~l_lane) == '0) && ((r_we & ~r_lane) == '0));
endmodule

// File: tb/sim_dpc_collide.sv
`timescale 1ns/1ps
module sim_dpc_collide;
  localparam int AW = 13;
  localparam int LN = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          master_mode;
  logic          l_en, l_wr, r_en, r_wr, l_busy_in, r_busy_in;
  logic [AW-1:0] l_addr, r_addr;
  logic [LN-1:0] l_lane, r_lane;
  logic          l_busy_out, r_busy_out;
  logic [LN-1:0] l_we, r_we;

  int    n_chk = 0;
  int    n_bad = 0;
  int    cycles = 0;
  string cur_req = "R11";

  // behavioural reference state
  int            m_owner;   // 0 none, 1 left, 2 right
  bit            m_bl, m_br;
  bit            p_len, p_ren;
  logic [AW-1:0] p_la, p_ra;

  always #10 clk = ~clk;

  dpc_collide #(.AW(AW), .LANES(LN)) u0 (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_en(l_en), .l_wr(l_wr), .l_addr(l_addr), .l_lane(l_lane),
    .r_en(r_en), .r_wr(r_wr), .r_addr(r_addr), .r_lane(r_lane),
    .l_busy_in(l_busy_in), .r_busy_in(r_busy_in),
    .l_busy_out(l_busy_out), .r_busy_out(r_busy_out),
    .l_we(l_we), .r_we(r_we)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles, expected fewer than 20000", cycles);
        report();
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
    end
  endtask

  task automatic set(bit le, bit lw, logic [AW-1:0] la, logic [LN-1:0] ll,
                     bit re, bit rw, logic [AW-1:0] ra, logic [LN-1:0] rl);
    l_en = le; l_wr = lw; l_addr = la; l_lane = ll;
    r_en = re; r_wr = rw; r_addr = ra; r_lane = rl;
  endtask

  // compare now, then advance the model at the clock edge
  task automatic cyc(int n);
    for (int k = 0; k < n; k++) begin
      bit match, ls, rs, lose_l, lose_r, blk_l, blk_r;
      int win;
      #1;
      match = l_en && r_en && (l_addr == r_addr);
      ls = l_en && p_len && (l_addr == p_la);
      rs = r_en && p_ren && (r_addr == p_ra);
      if (!match) win = 0;
      else if (m_owner != 0) win = m_owner;
      else if (rs && !ls) win = 2;
      else win = 1;
      lose_l = match && (win == 2);
      lose_r = match && (win == 1);
      blk_l = master_mode ? (lose_l || m_bl) : l_busy_in;
      blk_r = master_mode ? (lose_r || m_br) : r_busy_in;
      chk("l_busy_out", int'(l_busy_out), int'(m_bl));
      chk("r_busy_out", int'(r_busy_out), int'(m_br));
      chk("l_we", int'(l_we), (l_en && l_wr && !blk_l) ? int'(l_lane) : 0);
      chk("r_we", int'(r_we), (r_en && r_wr && !blk_r) ? int'(r_lane) : 0);
      @(posedge clk);
      if (!rst_n) begin
        m_owner = 0; m_bl = 0; m_br = 0; p_len = 0; p_ren = 0; p_la = '0; p_ra = '0;
      end else begin
        m_owner = win;
        m_bl = master_mode && lose_l;
        m_br = master_mode && lose_r;
        p_len = l_en; p_ren = r_en; p_la = l_addr; p_ra = r_addr;
      end
      @(negedge clk);
    end
  endtask

  localparam logic [AW-1:0] A = 13'h00AB;
  localparam logic [AW-1:0] B = 13'h0155;

  initial begin
    m_owner = 0; m_bl = 0; m_br = 0; p_len = 0; p_ren = 0; p_la = '0; p_ra = '0;
    rst_n = 1'b0; master_mode = 1'b1; l_busy_in = 1'b0; r_busy_in = 1'b0;
    set(0, 0, '0, '0, 0, 0, '0, '0);
    // R11: outputs quiet under reset
    cur_req = "R11";
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R2: both enabled, different addresses
    cur_req = "R2";
    set(1, 1, A, 2'b11, 1, 1, A + 13'd1, 2'b11); cyc(3);

    // R10: addresses differ only in the top bit
    cur_req = "R10";
    set(1, 1, A, 2'b11, 1, 1, A | 13'h1000, 2'b11); cyc(3);
    set(0, 0, '0, '0, 0, 0, '0, '0); cyc(1);

    // R4: simultaneous arrival, left wins; loser write blocked at once (R6)
    cur_req = "R4";
    set(1, 1, A, 2'b11, 1, 1, A, 2'b11); cyc(3);
    // R2/R6: left leaves, right keeps writing through trailing busy cycle
    cur_req = "R6";
    set(0, 0, A, 2'b00, 1, 1, A, 2'b11); cyc(2);
    set(0, 0, '0, '0, 0, 0, '0, '0); cyc(1);

    // R9: left writes A first, right reads A later -> right busy
    cur_req = "R9";
    set(1, 1, A, 2'b11, 0, 0, '0, '0); cyc(2);
    set(1, 1, A, 2'b11, 1, 0, A, 2'b11); cyc(3);
    set(0, 0, '0, '0, 0, 0, '0, '0); cyc(2);

    // R3: right arrives first, left joins later -> left loses
    cur_req = "R3";
    set(0, 0, '0, '0, 1, 1, A, 2'b01); cyc(2);
    set(1, 1, A, 2'b11, 1, 1, A, 2'b01); cyc(3);
    // R5: both move together to B, winner stays right
    cur_req = "R5";
    set(1, 1, B, 2'b11, 1, 1, B, 2'b10); cyc(3);
    // R1/R2: match ends, busy falls next cycle
    cur_req = "R1";
    set(1, 1, B, 2'b11, 1, 1, A, 2'b10); cyc(3);
    set(0, 0, '0, '0, 0, 0, '0, '0); cyc(1);

    // R8: lane patterns and reads
    cur_req = "R8";
    set(1, 1, B, 2'b10, 0, 0, '0, '0); cyc(1);
    set(1, 1, B, 2'b01, 1, 1, A, 2'b10); cyc(1);
    set(1, 0, B, 2'b11, 1, 0, A, 2'b11); cyc(1);
    set(0, 1, B, 2'b11, 1, 1, A, 2'b00); cyc(1);

    // R7: busy inputs ignored in master mode
    cur_req = "R7";
    l_busy_in = 1'b1; r_busy_in = 1'b1;
    set(1, 1, A, 2'b11, 1, 1, B, 2'b11); cyc(2);
    // R7: slave mode, no busy outputs, inputs hold off writes
    master_mode = 1'b0; l_busy_in = 1'b0; r_busy_in = 1'b0;
    set(1, 1, A, 2'b11, 1, 1, A, 2'b11); cyc(3);
    r_busy_in = 1'b1; cyc(2);
    l_busy_in = 1'b1; r_busy_in = 1'b0; cyc(2);
    l_busy_in = 1'b0; cyc(1);
    master_mode = 1'b1;
    set(0, 0, '0, '0, 0, 0, '0, '0); cyc(2);

    report();
  end
endmodule